// File: doc/BRIEF.md
# Command-Register MDIO Management Master

This block drives a clause-22 MDIO management bus. It is controlled through a single 32-bit command/status word. The host writes one word that holds a PHY address, a register address, a direction bit and, for writes, 16 data bits. If the word has both the busy bit and the enable bit set, the block generates MDC and shifts a complete 64-bit management frame onto MDIO. The busy bit stays set while the frame runs and clears by itself when the frame ends. On a read, the 16 bits taken from the PHY replace the low half of that same word. The host therefore only writes the command and then polls for busy to drop.

A frame sequencer is built around the states `ST_IDLE`, `ST_PRE`, `ST_HDR`, `ST_TA`, `ST_DATA` and `ST_DONE`. On an accepted launch, `ST_IDLE` moves to `ST_PRE`. Each falling MDC edge advances the bit index. The state moves from `ST_PRE` to `ST_HDR` after the last preamble bit, from `ST_HDR` to `ST_TA` after the 14 start/opcode/address bits, and from `ST_TA` to `ST_DATA` after the two turnaround bits. After the final data bit it moves from `ST_DATA` to `ST_DONE`. `ST_DONE` returns to `ST_IDLE` on the next clock and reports completion to the command register. A divider makes MDC from the system clock only while a frame is active. The number of internal PHYs is a parameter, and a command addressed past the last PHY is never put on the wire.

Top module: `mdio_cmd_master`

## Requirements
- R1: Command word layout: bits 15:0 data, bits 20:16 register address, bits 25:21 PHY address, bit 27 set for read and clear for write, bit 30 enable, bit 31 busy. A frame starts only when a host write has bits 31 and 30 both set and the PHY address is below NUM_PHYS.
- R2: Each frame is 64 MDC cycles. In order, MSB first: 32 ones, start bits 0 then 1, opcode 1,0 for read or 0,1 for write, five PHY address bits, five register address bits.
- R3: On a write, the master drives the turnaround as 1 then 0, then the 16 data bits MSB first, with the output enable high for all 64 bits.
- R4: On a read, the output enable is low for the two turnaround bits and the 16 data bits. The 16 bits sampled from MDIO, MSB first, replace bits 15:0 of the command word. Bits 30:16 keep their written value.
- R5: MDC has a period of CLK_DIV system clocks with equal high and low halves, and it rests low when no frame runs. MDIO output changes only while MDC falls and is held while MDC is high. Input is sampled as MDC rises.
- R6: Busy reads 1 from the clock after the launching write until the frame's final falling MDC edge, then reads 0. Host writes while busy is 1 change nothing, either in the command word or in the frame on the wire.
- R7: A launching command whose PHY address is NUM_PHYS or higher produces no MDC activity and leaves busy at 0. For a read, bits 15:0 return 0xFFFF; for a write, the written data stays.
- R8: A written word lacking bit 31 or bit 30 starts no frame. It is stored with busy 0 and the rest of the word as written.
- R9: After reset the command word is 0, MDC is low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Host write strobe for the command word |
| cmd_wdata | input | 32 | Command word written by the host |
| cmd_rdata | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
The bench builds the block with CLK_DIV = 4 and NUM_PHYS = 5. The short divider keeps a full 64-bit frame to 256 clocks, so table-driven reads and writes, a write issued mid-frame and the invalid-address cases all fit easily. With five PHYs, addresses 4 (the last valid one) and 5 (the first invalid one) sit on either side of the acceptance boundary. The even, small divider also makes the exact MDC period and half-period measurable in bench time.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 4 + 2 * ADDR_W;
    localparam int TA_BITS   = 2;
    localparam int FRAME_LEN = PRE_BITS + HDR_BITS + TA_BITS + DATA_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    localparam int BIT_BUSY = 31;
    localparam int BIT_EN   = 30;
    localparam int BIT_RD   = 27;
    localparam int PHY_LSB  = 21;
    localparam int REG_LSB  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA,
        ST_DONE
    } frame_state_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CNT_W-1:0] cnt;
    logic             wrap;

    assign wrap      = (cnt == CNT_W'(HALF - 1));
    assign rise_tick = run && wrap && !mdc;
    assign fall_tick = run && wrap && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TICKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_tick && fall_tick)); // R5
    AST_MDC_RESTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc); // R5
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdc,
    input  logic              mdio_i,
    output logic              run,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    localparam int END_PRE  = PRE_BITS - 1;
    localparam int END_HDR  = END_PRE + HDR_BITS;
    localparam int END_TA   = END_HDR + TA_BITS;
    localparam int END_DATA = FRAME_LEN - 1;

    frame_state_t     state, state_n;
    logic [IDX_W-1:0] idx, idx_n;
    logic [FRAME_LEN-1:0] frame;

    function automatic frame_state_t region(input logic [IDX_W-1:0] i);
        if (int'(i) <= END_PRE)      return ST_PRE;
        else if (int'(i) <= END_HDR) return ST_HDR;
        else if (int'(i) <= END_TA)  return ST_TA;
        else                         return ST_DATA;
    endfunction

    assign frame = {{PRE_BITS{1'b1}}, 2'b01,
                    is_read ? 2'b10 : 2'b01,
                    phy_addr, reg_addr, 2'b10, wr_data};

    // next-state logic
    always_comb begin
        state_n = state;
        idx_n   = idx;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n = ST_PRE;
                    idx_n   = '0;
                end
            end
            ST_PRE, ST_HDR, ST_TA, ST_DATA: begin
                if (fall_tick) begin
                    if (int'(idx) == END_DATA) begin
                        state_n = ST_DONE;
                    end else begin
                        idx_n   = idx + 1'b1;
                        state_n = region(idx + 1'b1);
                    end
                end
            end
            ST_DONE: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // state register and input capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            rd_data <= '0;
        end else begin
            state <= state_n;
            idx   <= idx_n;
            if (rise_tick && is_read && state == ST_DATA)
                rd_data <= {rd_data[DATA_W-2:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        run     = 1'b0;
        done    = 1'b0;
        mdio_oe = 1'b0;
        mdio_o  = 1'b1;
        unique case (state)
            ST_IDLE: ;
            ST_PRE, ST_HDR: begin
                run     = 1'b1;
                mdio_oe = 1'b1;
                mdio_o  = frame[END_DATA - int'(idx)];
            end
            ST_TA, ST_DATA: begin
                run     = 1'b1;
                mdio_oe = !is_read;
                mdio_o  = is_read ? 1'b1 : frame[END_DATA - int'(idx)];
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    AST_HOLD_WHILE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R5
    AST_RELEASE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && (state == ST_TA || state == ST_DATA)) |-> !mdio_oe); // R4
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> state == ST_IDLE); // R6
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
    import mdio_cmd_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int NUM_PHYS = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [31:0]       cmd_reg;
    logic              busy, launch, phy_ok, start;
    logic              run, rise_tick, fall_tick, done;
    logic [DATA_W-1:0] rd_data;

    assign busy   = cmd_reg[BIT_BUSY];
    assign launch = cmd_wdata[BIT_BUSY] && cmd_wdata[BIT_EN];
    assign phy_ok = int'(cmd_wdata[PHY_LSB +: ADDR_W]) < NUM_PHYS;
    assign start  = cmd_we && !busy && launch && phy_ok;
    assign cmd_rdata = cmd_reg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_reg <= '0;
        end else if (cmd_we && !busy) begin
            if (start)
                cmd_reg <= cmd_wdata;
            else if (launch && cmd_wdata[BIT_RD])
                cmd_reg <= {1'b0, cmd_wdata[30:16], {DATA_W{1'b1}}};
            else
                cmd_reg <= {1'b0, cmd_wdata[30:0]};
        end else if (done) begin
            cmd_reg[BIT_BUSY] <= 1'b0;
            if (cmd_reg[BIT_RD])
                cmd_reg[DATA_W-1:0] <= rd_data;
        end
    end

    mdio_clk_gen #(.CLK_DIV(CLK_DIV)) i_clk_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm i_frame_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_read   (cmd_reg[BIT_RD]),
        .phy_addr  (cmd_reg[PHY_LSB +: ADDR_W]),
        .reg_addr  (cmd_reg[REG_LSB +: ADDR_W]),
        .wr_data   (cmd_reg[DATA_W-1:0]),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdc       (mdc),
        .mdio_i    (mdio_i),
        .run       (run),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .rd_data   (rd_data)
    );

    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && $past(cmd_we) && busy) |-> (cmd_reg == $past(cmd_reg))); // R6
    AST_VALID_PHY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> int'(cmd_reg[PHY_LSB +: ADDR_W]) < NUM_PHYS); // R7
    AST_MDC_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> busy); // R6
    AST_BUSY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cmd_reg[BIT_EN]); // R1
endmodule

// File: tb/test_mdio_cmd_master.sv
`timescale 1ns/1ps
module test_mdio_cmd_master;
    localparam int CLK_DIV  = 4;
    localparam int NUM_PHYS = 5;
    localparam int NVEC     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    // {read, phy, reg, data}
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b0, 5'd0, 5'd2,  16'hA5C3},
        {1'b1, 5'd4, 5'd31, 16'h8001},
        {1'b1, 5'd1, 5'd3,  16'h3C5A},
        {1'b0, 5'd4, 5'd0,  16'h0000}
    };

    always #2.5 clk = ~clk;

    mdio_cmd_master #(.CLK_DIV(CLK_DIV), .NUM_PHYS(NUM_PHYS)) i_mdio_cmd_master (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    // bus monitor and PHY model
    logic [63:0] cap_o, cap_oe;
    int          rise_cnt = 0;
    logic [15:0] phy_data = '0;
    realtime     t_rise = 0.0;
    realtime     t_prev = 0.0;
    int          bad_timing = 0;

    always @(posedge mdc) begin
        if (rise_cnt < 64) begin
            cap_o[63 - rise_cnt]  = mdio_o;
            cap_oe[63 - rise_cnt] = mdio_oe;
        end
        if (rise_cnt > 0 && ($realtime - t_prev) != CLK_DIV * 5.0)
            bad_timing++;
        t_prev = $realtime;
        t_rise = $realtime;
        rise_cnt++;
    end

    always @(negedge mdc) begin
        if (($realtime - t_rise) != CLK_DIV * 2.5)
            bad_timing++;
        if (rise_cnt >= 48 && rise_cnt < 64)
            mdio_i = phy_data[15 - (rise_cnt - 48)];
        else
            mdio_i = 1'b1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [31:0] w);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wait_idle(output int cycles);
        cycles = 0;
        while (cmd_rdata[31] && cycles < 2000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    function automatic logic [31:0] mk_cmd(input logic [26:0] v);
        return {2'b11, 2'b00, v[26], 1'b0, v[25:21], v[20:16], v[15:0]};
    endfunction

    function automatic logic [63:0] mk_frame(input logic [26:0] v);
        return {32'hFFFF_FFFF, 2'b01, v[26] ? 2'b10 : 2'b01,
                v[25:21], v[20:16], 2'b10, v[15:0]};
    endfunction

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        logic [63:0] mask, expf;
        logic [31:0] c, first;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset word", 64'(cmd_rdata), 64'h0);
        check("R9 reset pins", {62'h0, mdc, mdio_oe}, 64'h0);

        // table of vectors
        for (int k = 0; k < NVEC; k++) begin
            c = mk_cmd(VEC[k]);
            phy_data = VEC[k][26] ? VEC[k][15:0] : 16'h0;
            if (VEC[k][26]) c[15:0] = 16'h0;
            rise_cnt = 0;
            bad_timing = 0;
            host_write(c);
            check("R6 busy after launch", 64'(cmd_rdata[31]), 64'h1);
            wait_idle(cyc);
            check("R2 rise count", 64'(rise_cnt), 64'd64);
            expf = mk_frame(VEC[k]);
            mask = VEC[k][26] ? {{46{1'b1}}, 18'h0} : '1;
            check("R2 R3 frame bits", cap_o & mask, expf & mask);
            check(VEC[k][26] ? "R4 read oe" : "R3 write oe", cap_oe, mask);
            check(VEC[k][26] ? "R4 read result" : "R6 write result",
                  64'(cmd_rdata), 64'({1'b0, c[30:16], VEC[k][15:0]}));
            check("R5 MDC timing", 64'(bad_timing), 64'h0);
            check("R5 MDC idle low", 64'(mdc), 64'h0);
        end

        // R6: write during busy is ignored
        first = mk_cmd({1'b0, 5'd2, 5'd7, 16'h1234});
        rise_cnt = 0;
        host_write(first);
        repeat (30) @(negedge clk);
        host_write(mk_cmd({1'b1, 5'd3, 5'd9, 16'hFFFF}));
        check("R6 word unchanged in busy", 64'(cmd_rdata), 64'(first));
        wait_idle(cyc);
        check("R6 frame unchanged", cap_o, mk_frame({1'b0, 5'd2, 5'd7, 16'h1234}));
        check("R6 busy cleared", 64'(cmd_rdata), 64'({1'b0, first[30:0]}));

        // R7: invalid PHY read and write
        rise_cnt = 0;
        host_write(mk_cmd({1'b1, 5'd5, 5'd1, 16'h0000}));
        repeat (40) @(negedge clk);
        check("R7 bad read word", 64'(cmd_rdata), 64'h48A1_FFFF);
        check("R7 no MDC on bad read", 64'(rise_cnt), 64'h0);
        host_write(mk_cmd({1'b0, 5'd31, 5'd1, 16'h00AA}));
        repeat (40) @(negedge clk);
        check("R7 bad write word", 64'(cmd_rdata), 64'h43E1_00AA);
        check("R7 no MDC on bad write", 64'(rise_cnt), 64'h0);

        // R8 / R1: missing busy or enable
        host_write(32'h4022_0055);
        repeat (40) @(negedge clk);
        check("R8 no busy bit", {32'h0, cmd_rdata}, 64'h4022_0055);
        host_write(32'h8822_0055);
        repeat (40) @(negedge clk);
        check("R1 no enable bit", {32'h0, cmd_rdata}, 64'h0822_0055);
        check("R8 no MDC", 64'(rise_cnt), 64'h0);

        // R9: reset mid-frame
        host_write(mk_cmd({1'b0, 5'd1, 5'd1, 16'h0F0F}));
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset mid-frame", {cmd_rdata, 30'h0, mdc, mdio_oe}, 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule